// File: doc/BRIEF.md
# DMA Channel Arm and Trigger Control Registers

This block is the register front end of a five-channel DMA controller. Software reaches it through an 8-bit special-function-register port with fixed byte addresses. Through that port it can:

- arm or disarm each channel;
- post a software start request for any channel;
- abort any set of channels in one write;
- load the 16-bit pointer to channel 0's configuration record.

The data mover reports three things per channel through simple strobes and levels: a transfer has begun, a transfer has finished, and the channel runs in a repetitive mode. The block uses these to clear pending requests and to disarm channels that have finished a one-shot transfer.

The block has three outputs toward the mover. One is a per-channel armed level. Another is a per-channel software-trigger level, which is raised only while a request is pending and its channel is armed. The last is a one-cycle abort pulse for each channel that was aborted. Register reads are combinational from the current state, and writes take effect at the next rising clock edge. Reset is synchronous and active high.

Top module: `dma_arm_ctrl`

## Requirements
- R1: After reset, every arm bit, request bit, abort pulse, trigger output and both configuration-pointer bytes are 0.
- R2: A write to address 0xD6 with bit 7 at 0 loads bits 4:0 into the arm bits of channels 4..0, with bit n for channel n. A read of 0xD6 returns the arm bits in 4:0 and 0 in bits 7:5.
- R3: A write to 0xD6 with bit 7 at 1 is an abort. It uses bits 4:0 of that byte as a channel mask. Each selected channel has its arm bit cleared and its pending request cleared at the next edge. Each selected channel also gets a one-cycle pulse on `ch_abort` in the cycle after the write. Unselected channels keep their arm bits.
- R4: When `ch_done[n]` is 1 and `ch_repeat[n]` is 0, arm bit n clears at the next edge, unless that same cycle holds a non-abort write to 0xD6.
- R5: When `ch_repeat[n]` is 1, a completion leaves arm bit n set. A non-abort write to 0xD6 in the same cycle as a completion sets the arm bits to the written value.
- R6: A write to 0xD7 sets request bit n for each 1 in bits 4:0, and a 0 bit has no effect. A read of 0xD7 returns the request bits in 4:0 and 0 in bits 7:5.
- R7: `ch_start[n]` clears request bit n at the next edge. A write of 1 to that bit in the same cycle leaves it set.
- R8: `ch_trigger[n]` is 1 exactly while request bit n and arm bit n are both 1. A request for an unarmed channel stays pending.
- R9: Writes to 0xD4 and 0xD5 load the low and high bytes of the 16-bit channel-0 configuration pointer. The pointer appears on `cfg_ptr`, and each byte reads back at its own address.
- R10: Writes to any other address change no state, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_wr_en | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register byte address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr` (combinational) |
| ch_start | input | NUM_CH | Per-channel transfer-begun strobe |
| ch_done | input | NUM_CH | Per-channel transfer-finished strobe |
| ch_repeat | input | NUM_CH | Per-channel repetitive-mode level |
| ch_armed | output | NUM_CH | Per-channel armed level |
| ch_trigger | output | NUM_CH | Pending request on an armed channel |
| ch_abort | output | NUM_CH | One-cycle abort pulse per aborted channel |
| cfg_ptr | output | 16 | Channel-0 configuration pointer |

## Verification
The assertions check four things on every cycle:

- a one-shot completion disarms its channel;
- a repetitive channel stays armed without a write;
- an abort pulse never coexists with its channel's arm bit, and the pulse follows the aborting write;
- request bits are set by writes and otherwise change only through start strobes or aborts.

Several properties involve chosen collisions: an arm write meeting a completion, a start strobe meeting a request write, and a request posted before its channel is armed. Only the bench scenarios can show these. The bench scenarios also cover the exact read-back values at each address and the pointer byte lanes. These are checked against a bench model that runs under mixed directed and random traffic.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

    localparam int unsigned MAX_CH = 5;

    localparam logic [7:0] ADDR_PTR_LO = 8'hD4;
    localparam logic [7:0] ADDR_PTR_HI = 8'hD5;
    localparam logic [7:0] ADDR_ARM    = 8'hD6;
    localparam logic [7:0] ADDR_REQ    = 8'hD7;

    localparam int unsigned ABORT_BIT = 7;

    typedef struct packed {
        logic arm_load;
        logic abort;
        logic req_set;
        logic ptr_lo;
        logic ptr_hi;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic wr_en,
                                             input logic [7:0] addr,
                                             input logic [7:0] data);
        wr_dec_t d;
        d          = '0;
        d.arm_load = wr_en && (addr == ADDR_ARM) && !data[ABORT_BIT];
        d.abort    = wr_en && (addr == ADDR_ARM) &&  data[ABORT_BIT];
        d.req_set  = wr_en && (addr == ADDR_REQ);
        d.ptr_lo   = wr_en && (addr == ADDR_PTR_LO);
        d.ptr_hi   = wr_en && (addr == ADDR_PTR_HI);
        return d;
    endfunction

endpackage

// File: rtl/dmactl_arm_bank.sv
module dmactl_arm_bank #(
    parameter int unsigned NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              abort,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] done,
    input  logic [NUM_CH-1:0] repeat_mode,
    output logic [NUM_CH-1:0] armed,
    output logic [NUM_CH-1:0] abort_pulse
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic one_shot_end;
        assign one_shot_end = done[g] && !repeat_mode[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                armed[g] <= 1'b0;
            end else if (load) begin
                armed[g] <= wbits[g];
            end else if ((abort && wbits[g]) || one_shot_end) begin
                armed[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                abort_pulse[g] <= 1'b0;
            end else begin
                abort_pulse[g] <= abort && wbits[g];
            end
        end
    end
endmodule

// File: rtl/dmactl_req_bank.sv
module dmactl_req_bank #(
    parameter int unsigned NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              abort,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] start,
    output logic [NUM_CH-1:0] pending
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic set_bit;
        logic clr_bit;
        assign set_bit = set_en && wbits[g];
        assign clr_bit = start[g] || (abort && wbits[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                pending[g] <= 1'b0;
            end else if (set_bit) begin
                pending[g] <= 1'b1;
            end else if (clr_bit) begin
                pending[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dmactl_ptr_reg.sv
module dmactl_ptr_reg #(
    parameter int unsigned PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wbyte,
    output logic [PTR_W-1:0] ptr
);
    localparam int unsigned NBYTES = PTR_W / 8;

    logic [NBYTES-1:0] byte_we;
    assign byte_we = NBYTES'({wr_hi, wr_lo});

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr[b*8 +: 8] <= 8'h00;
            end else if (byte_we[b]) begin
                ptr[b*8 +: 8] <= wbyte;
            end
        end
    end
endmodule

// File: rtl/dma_arm_ctrl.sv
module dma_arm_ctrl
    import dmactl_pkg::*;
#(
    parameter int unsigned NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sfr_wr_en,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    input  logic [NUM_CH-1:0] ch_start,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_repeat,
    output logic [NUM_CH-1:0] ch_armed,
    output logic [NUM_CH-1:0] ch_trigger,
    output logic [NUM_CH-1:0] ch_abort,
    output logic [15:0]       cfg_ptr
);
    localparam int unsigned PTR_W = 16;

    wr_dec_t            dec;
    logic [NUM_CH-1:0]  wbits;
    logic [NUM_CH-1:0]  req_pend;

    assign dec   = decode_write(sfr_wr_en, sfr_addr, sfr_wdata);
    assign wbits = sfr_wdata[NUM_CH-1:0];

    dmactl_arm_bank #(.NUM_CH(NUM_CH)) u_arm (
        .clk         (clk),
        .rst         (rst),
        .load        (dec.arm_load),
        .abort       (dec.abort),
        .wbits       (wbits),
        .done        (ch_done),
        .repeat_mode (ch_repeat),
        .armed       (ch_armed),
        .abort_pulse (ch_abort)
    );

    dmactl_req_bank #(.NUM_CH(NUM_CH)) u_req (
        .clk     (clk),
        .rst     (rst),
        .set_en  (dec.req_set),
        .abort   (dec.abort),
        .wbits   (wbits),
        .start   (ch_start),
        .pending (req_pend)
    );

    dmactl_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .wr_lo (dec.ptr_lo),
        .wr_hi (dec.ptr_hi),
        .wbyte (sfr_wdata),
        .ptr   (cfg_ptr)
    );

    assign ch_trigger = req_pend & ch_armed;

    always_comb begin
        sfr_rdata = 8'h00;
        unique case (sfr_addr)
            ADDR_PTR_LO: sfr_rdata = cfg_ptr[7:0];
            ADDR_PTR_HI: sfr_rdata = cfg_ptr[15:8];
            ADDR_ARM:    sfr_rdata[NUM_CH-1:0] = ch_armed;
            ADDR_REQ:    sfr_rdata[NUM_CH-1:0] = req_pend;
            default:     sfr_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/dmactl_chk.sv
module dmactl_chk
    import dmactl_pkg::*;
#(
    parameter int unsigned NUM_CH = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              sfr_wr_en,
    input logic [7:0]        sfr_addr,
    input logic [7:0]        sfr_wdata,
    input logic [7:0]        sfr_rdata,
    input logic [NUM_CH-1:0] ch_start,
    input logic [NUM_CH-1:0] ch_done,
    input logic [NUM_CH-1:0] ch_repeat,
    input logic [NUM_CH-1:0] ch_armed,
    input logic [NUM_CH-1:0] ch_abort,
    input logic [NUM_CH-1:0] req_pend
);
    logic arm_wr;
    logic arm_load_wr;
    logic req_wr;
    assign arm_wr      = sfr_wr_en && (sfr_addr == ADDR_ARM);
    assign arm_load_wr = arm_wr && !sfr_wdata[ABORT_BIT];
    assign req_wr      = sfr_wr_en && (sfr_addr == ADDR_REQ);

    AST_ARM_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr == ADDR_ARM) |-> (sfr_rdata[7:5] == 3'b000)); // R2

    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ch_abort == ($past(arm_wr && sfr_wdata[ABORT_BIT]) ? $past(sfr_wdata[NUM_CH-1:0]) : '0))); // R3

    AST_ABORT_DISARMS: assert property (@(posedge clk) disable iff (rst)
        ((ch_abort & ch_armed) == '0)); // R3

    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
        !arm_load_wr |=> ((ch_armed & $past(ch_done & ~ch_repeat)) == '0)); // R4

    AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !arm_wr |=> ((~ch_armed & $past(ch_armed & ch_repeat)) == '0)); // R5

    AST_REQ_SET: assert property (@(posedge clk) disable iff (rst)
        req_wr |=> ((req_pend & $past(sfr_wdata[NUM_CH-1:0])) == $past(sfr_wdata[NUM_CH-1:0]))); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!req_wr && !arm_wr && (ch_start == '0)) |=> $stable(req_pend)); // R7
endmodule

bind dma_arm_ctrl dmactl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sfr_wr_en (sfr_wr_en),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .ch_start  (ch_start),
    .ch_done   (ch_done),
    .ch_repeat (ch_repeat),
    .ch_armed  (ch_armed),
    .ch_abort  (ch_abort),
    .req_pend  (req_pend)
);

// File: tb/sim_dma_arm_ctrl.sv
`timescale 1ns/1ps
module sim_dma_arm_ctrl;
    localparam int NC = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [7:0]    addr;
    logic [7:0]    wdata;
    logic [7:0]    rdata;
    logic [NC-1:0] st, dn, rp;
    logic [NC-1:0] armed, trig, abrt;
    logic [15:0]   ptr;

    logic [NC-1:0] m_arm, m_req, m_abort;
    logic [15:0]   m_ptr;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    dma_arm_ctrl #(.NUM_CH(NC)) u0 (
        .clk(clk), .rst(rst), .sfr_wr_en(wr_en), .sfr_addr(addr),
        .sfr_wdata(wdata), .sfr_rdata(rdata), .ch_start(st), .ch_done(dn),
        .ch_repeat(rp), .ch_armed(armed), .ch_trigger(trig),
        .ch_abort(abrt), .cfg_ptr(ptr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'hD4:   return m_ptr[7:0];
            8'hD5:   return m_ptr[15:8];
            8'hD6:   return {3'b000, m_arm};
            8'hD7:   return {3'b000, m_req};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [NC-1:0] next_arm(input logic w, input logic [7:0] a,
            input logic [7:0] d, input logic [NC-1:0] dn_i, input logic [NC-1:0] rp_i);
        logic [NC-1:0] fin;
        fin = dn_i & ~rp_i;
        if (w && a == 8'hD6 && !d[7]) return d[NC-1:0];
        if (w && a == 8'hD6 &&  d[7]) return m_arm & ~d[NC-1:0] & ~fin;
        return m_arm & ~fin;
    endfunction

    function automatic logic [NC-1:0] next_req(input logic w, input logic [7:0] a,
            input logic [7:0] d, input logic [NC-1:0] s);
        logic [NC-1:0] set, clr;
        set = (w && a == 8'hD7) ? d[NC-1:0] : '0;
        clr = s | ((w && a == 8'hD6 && d[7]) ? d[NC-1:0] : '0);
        return (m_req & ~clr) | set;
    endfunction

    task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                        input logic [NC-1:0] s, input logic [NC-1:0] dn_i,
                        input logic [NC-1:0] rp_i);
        logic [NC-1:0] na, nr, nab;
        logic [15:0]   np;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; st = s; dn = dn_i; rp = rp_i;
        na  = next_arm(w, a, d, dn_i, rp_i);
        nr  = next_req(w, a, d, s);
        nab = (w && a == 8'hD6 && d[7]) ? d[NC-1:0] : '0;
        np  = m_ptr;
        if (w && a == 8'hD4) np[7:0]  = d;
        if (w && a == 8'hD5) np[15:8] = d;
        @(posedge clk);
        #1;
        m_arm = na; m_req = nr; m_abort = nab; m_ptr = np;
    endtask

    task automatic check_outs(input string req);
        chk({req, " armed"},   16'(armed), 16'(m_arm));
        chk({req, " abort"},   16'(abrt),  16'(m_abort));
        chk({req, " trigger"}, 16'(trig),  16'(m_req & m_arm));
        chk({req, " ptr"},     ptr,        m_ptr);
    endtask

    task automatic check_rd(input logic [7:0] a, input string req);
        wr_en = 1'b0; st = '0; dn = '0; addr = a;
        #1;
        chk({req, " read"}, 16'(rdata), 16'(exp_rd(a)));
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 8'h00, '0, '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ra, rd;
        rst = 1'b1; wr_en = 0; addr = 0; wdata = 0; st = 0; dn = 0; rp = 0;
        m_arm = 0; m_req = 0; m_abort = 0; m_ptr = 0;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;

        // R1: reset state
        check_outs("R1");
        check_rd(8'hD4, "R1"); check_rd(8'hD5, "R1");
        check_rd(8'hD6, "R1"); check_rd(8'hD7, "R1");

        // R2: arm load and read-back with zero upper bits
        step(1, 8'hD6, 8'h75, '0, '0, '0);
        check_outs("R2"); check_rd(8'hD6, "R2");
        step(1, 8'hD6, 8'h1F, '0, '0, '0);
        step(1, 8'hD7, 8'h03, '0, '0, '0);
        check_outs("R8");

        // R3: abort channel 0 only
        step(1, 8'hD6, 8'h81, '0, '0, '0);
        check_outs("R3"); check_rd(8'hD6, "R3"); check_rd(8'hD7, "R3");
        chk("R3 pulse", 16'(abrt), 16'h0001);
        idle();
        check_outs("R3");
        chk("R3 pulse end", 16'(abrt), 16'h0000);

        // R4/R5: completion on one-shot channel 1 and repetitive channel 2
        step(0, 8'h00, 8'h00, '0, 5'h06, 5'h04);
        check_outs("R4"); check_rd(8'hD6, "R5");
        chk("R4 arm", 16'(armed), 16'h001C);
        // R5: arm write meets a completion
        step(1, 8'hD6, 8'h08, '0, 5'h08, '0);
        check_outs("R5");
        chk("R5 arm", 16'(armed), 16'h0008);

        // R8: request on an unarmed channel stays pending
        step(1, 8'hD7, 8'h10, '0, '0, '0);
        check_outs("R8"); check_rd(8'hD7, "R8");
        step(1, 8'hD6, 8'h18, '0, '0, '0);
        check_outs("R8");
        chk("R8 trig4", 16'(trig[4]), 16'h0001);

        // R7: start clears; start and write of 1 together keep the bit
        step(0, 8'h00, 8'h00, 5'h10, '0, '0);
        check_outs("R7"); check_rd(8'hD7, "R7");
        step(1, 8'hD7, 8'h04, 5'h04, '0, '0);
        check_rd(8'hD7, "R7");
        // R6: writing zeros changes nothing
        step(1, 8'hD7, 8'h00, '0, '0, '0);
        check_rd(8'hD7, "R6"); check_outs("R6");

        // R9: pointer byte lanes
        step(1, 8'hD4, 8'hA5, '0, '0, '0);
        step(1, 8'hD5, 8'h3C, '0, '0, '0);
        check_outs("R9"); check_rd(8'hD4, "R9"); check_rd(8'hD5, "R9");
        chk("R9 ptr", ptr, 16'h3CA5);

        // R10: other addresses
        step(1, 8'h55, 8'hFF, '0, '0, '0);
        check_outs("R10"); check_rd(8'h55, "R10"); check_rd(8'hD8, "R10");

        // Random traffic against the model
        for (int i = 0; i < 600; i++) begin
            case ($urandom % 6)
                0: ra = 8'hD4;
                1: ra = 8'hD5;
                2, 3: ra = 8'hD6;
                4: ra = 8'hD7;
                default: ra = 8'($urandom);
            endcase
            rd = 8'($urandom);
            if (ra == 8'hD6 && ($urandom % 4) != 0) rd[7] = 1'b0;
            step(1'($urandom), ra, rd,
                 NC'($urandom & $urandom), NC'($urandom & $urandom), NC'($urandom));
            check_outs("R3 R4 R5 R8 random");
            check_rd(8'hD4 + 8'($urandom % 4), "R2 R6 R9 random");
        end

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule